// File: doc/BRIEF.md
# Programmable Counter/Timer Channel

This block is one channel of a multi-channel counter/timer peripheral. It holds a control byte, a time constant byte, an 8-bit down counter and an 8-bit prescaler. In timer mode the counter steps down once every 16 or once every 256 system clocks. In counter mode it steps down once for each chosen edge of an external clock/trigger pin. That pin is asynchronous, so it is synchronized to the system clock before its edges are detected. When the count runs out, the counter reloads itself from the time constant, the channel gives a one-cycle zero-count pulse and, if enabled, raises an interrupt request that stays up until it is acknowledged.

The host writes bytes through a single synchronous write port. A byte with bit 0 set is a control word. When that control word also has bit 2 set, the next byte written is taken as the time constant. The down counter can be read at any time on `rd_data` and shows how many steps are left before zero. A timer can start as soon as its time constant is loaded, or it can wait for a trigger edge on the external pin.

Top module: `cnt_tmr_chan`

## Requirements
- R1: After reset, `rd_data` is 0, `irq` is 0 and `zc_pulse` is 0, and nothing counts until a time constant is loaded.
- R2: A written byte with bit 0 = 1 is a control word. Its fields are: bit 7 interrupt enable, bit 6 counter mode (1) or timer mode (0), bit 5 divide by 256 (1) or by 16 (0), bit 4 rising edge (1) or falling edge (0), bit 3 trigger start, bit 2 time constant follows, bit 1 soft reset. A byte with bit 0 = 0 that arrives when no time constant is expected has no effect.
- R3: After a control word with bit 2 set, the next written byte is loaded into both the time constant and the down counter, so `rd_data` shows it on the cycle after the write.
- R4: In timer mode the counter steps down on every 16th clock (bit 5 = 0) or every 256th clock (bit 5 = 1). The first step comes 16 or 256 clocks after the clock edge that started the timer.
- R5: In counter mode each selected edge of `ext_clk_trg` steps the counter down once. The new value appears after the third rising clock edge that follows the pin change, not sooner.
- R6: When a step is taken with the counter at 1, the counter reloads from the time constant and `zc_pulse` is high for exactly one cycle.
- R7: A time constant of 0 counts 256 steps between zero-count pulses, and the counter reads 255 after the first step.
- R8: At each zero count with bit 7 set, `irq` rises and stays high until `irq_ack`. With bit 7 clear, `irq` stays low.
- R9: In timer mode with bit 3 set, the count holds after the time constant load until the selected edge of `ext_clk_trg` is detected. The first step then comes 16 (or 256) clocks later.
- R10: A control word with bit 1 set stops counting, freezes the counter value and clears a pending `irq`.
- R11: A hardware reset clears a pending `irq` and stops a running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 8 | Control word or time constant byte |
| ext_clk_trg | input | 1 | Asynchronous external count clock or trigger |
| irq_ack | input | 1 | Clears the pending interrupt request |
| rd_data | output | 8 | Present down counter value |
| zc_pulse | output | 1 | One-cycle pulse at each zero count |
| irq | output | 1 | Pending interrupt request |

## Verification
The counter is visible on every cycle, so a wrong prescaler phase or a wrong synchronizer depth shows up as a misplaced step at once. The bench therefore compares `rd_data` and `zc_pulse` on every clock of each timer run against a count it works out from the clock number. In counter mode it checks the value one cycle before and on the cycle of the expected step, so an edge that arrives a cycle early or late is caught. A wrong reload source, or wrong handling of a zero time constant, shows at the first zero count: the value that follows is wrong, or the pulses come at the wrong spacing.

// File: rtl/ctc_pkg.sv
package ctc_pkg;
    localparam int DW = 8;

    // control word bit positions
    localparam int B_IRQ_EN   = 7;
    localparam int B_CNT_MODE = 6;
    localparam int B_DIV_HI   = 5;
    localparam int B_RISE     = 4;
    localparam int B_TRIG     = 3;
    localparam int B_TC_NEXT  = 2;
    localparam int B_SOFT_RST = 1;
    localparam int B_IS_CTRL  = 0;

    typedef struct packed {
        logic [DW-1:0] ctrl;
        logic [DW-1:0] tc;
        logic [DW-1:0] cnt;
        logic          expect_tc;
        logic          run;
        logic          armed;
        logic          irq;
        logic          zc;
    } chan_st_t;
endpackage

// File: rtl/ctc_edge_sync.sv
module ctc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sh_q, sh_d;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], async_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise =  sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall = ~sh_q[STAGES-1] &  sh_q[STAGES];

    AST_EDGE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R5
endmodule

// File: rtl/ctc_prescaler.sv
module ctc_prescaler #(
    parameter int LO_LOG = 4,
    parameter int HI_LOG = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    input  logic sel_hi,
    output logic tick
);
    localparam int W = HI_LOG;
    localparam logic [LO_LOG-1:0] LO_MAX = '1;
    localparam logic [W-1:0]      HI_MAX = '1;

    logic [W-1:0] pc_q, pc_d;

    always_comb begin
        if (clr)     pc_d = '0;
        else if (en) pc_d = pc_q + W'(1);
        else         pc_d = pc_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    assign tick = en && (sel_hi ? (pc_q == HI_MAX) : (pc_q[LO_LOG-1:0] == LO_MAX));

    AST_PRESC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |=> (pc_q == $past(pc_q) + W'(1))); // R4
    AST_PRESC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(pc_q)); // R4
endmodule

// File: rtl/cnt_tmr_chan.sv
module cnt_tmr_chan
    import ctc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          ext_clk_trg,
    input  logic          irq_ack,
    output logic [DW-1:0] rd_data,
    output logic          zc_pulse,
    output logic          irq
);
    chan_st_t st_q, st_d;
    logic rise, fall, tick, sel_edge, cmode, step, presc_clr;

    ctc_edge_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ext_clk_trg), .rise(rise), .fall(fall)
    );

    ctc_prescaler #(.LO_LOG(4), .HI_LOG(8)) u_presc (
        .clk(clk), .rst_n(rst_n),
        .en(st_q.run && !cmode), .clr(presc_clr),
        .sel_hi(st_q.ctrl[B_DIV_HI]), .tick(tick)
    );

    assign cmode    = st_q.ctrl[B_CNT_MODE];
    assign sel_edge = st_q.ctrl[B_RISE] ? rise : fall;
    assign step     = st_q.run && (cmode ? sel_edge : tick);

    always_comb begin
        st_d      = st_q;
        st_d.zc   = 1'b0;
        presc_clr = 1'b0;

        if (irq_ack) st_d.irq = 1'b0;

        if (step) begin
            if (st_q.cnt == DW'(1)) begin
                st_d.cnt = st_q.tc;
                st_d.zc  = 1'b1;
                if (st_q.ctrl[B_IRQ_EN]) st_d.irq = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - DW'(1);
            end
        end

        if (st_q.armed && !cmode && sel_edge) begin
            st_d.run   = 1'b1;
            st_d.armed = 1'b0;
            presc_clr  = 1'b1;
        end

        if (wr_en) begin
            if (st_q.expect_tc) begin
                st_d.tc        = wr_data;
                st_d.cnt       = wr_data;
                st_d.expect_tc = 1'b0;
                presc_clr      = 1'b1;
                if (cmode || !st_q.ctrl[B_TRIG]) begin
                    st_d.run   = 1'b1;
                    st_d.armed = 1'b0;
                end else begin
                    st_d.run   = 1'b0;
                    st_d.armed = 1'b1;
                end
            end else if (wr_data[B_IS_CTRL]) begin
                st_d.ctrl = wr_data;
                if (wr_data[B_SOFT_RST]) begin
                    st_d.run       = 1'b0;
                    st_d.armed     = 1'b0;
                    st_d.irq       = 1'b0;
                    st_d.expect_tc = 1'b0;
                end
                if (wr_data[B_TC_NEXT]) begin
                    st_d.run       = 1'b0;
                    st_d.armed     = 1'b0;
                    st_d.expect_tc = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data  = st_q.cnt;
    assign zc_pulse = st_q.zc;
    assign irq      = st_q.irq;

    AST_RELOAD_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        zc_pulse |-> (rd_data == st_q.tc)); // R6
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(st_q.ctrl[B_IRQ_EN])); // R8
    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack && !(wr_en && !st_q.expect_tc && wr_data[B_IS_CTRL] && wr_data[B_SOFT_RST]))
        |=> irq); // R8
    AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !(wr_en && st_q.expect_tc)) |=> $stable(rd_data)); // R10
endmodule

// File: tb/tb_cnt_tmr_chan.sv
module tb_cnt_tmr_chan;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       ext_clk_trg = 1'b0;
    logic       irq_ack = 1'b0;
    logic [7:0] rd_data;
    logic       zc_pulse, irq;

    int errors = 0;
    int checks = 0;
    int zc_seen = 0;

    cnt_tmr_chan dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .ext_clk_trg(ext_clk_trg), .irq_ack(irq_ack),
        .rd_data(rd_data), .zc_pulse(zc_pulse), .irq(irq)
    );

    always #4 clk = ~clk;

    always @(negedge clk) if (zc_pulse) zc_seen++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // called at a negedge; returns at the negedge after the capturing edge
    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic timer_run(input int tc, input bit hi, input int periods,
                             input bit irqen, input bit inject);
        int div = hi ? 256 : 16;
        int eff = (tc == 0) ? 256 : tc;
        wr(8'h05 | (irqen ? 8'h80 : 8'h00) | (hi ? 8'h20 : 8'h00));
        wr(tc[7:0]);
        chk("R3 load", rd_data, tc);
        for (int k = 1; k <= div * eff * periods; k++) begin
            if (k == 1 && inject) begin
                wr_en = 1'b1;
                wr_data = 8'h40;   // bit 0 clear: must be ignored (R2)
                @(negedge clk);
                wr_en = 1'b0;
            end else begin
                @(negedge clk);
            end
            chk("R4 timer count", rd_data, (eff - ((k / div) % eff)) % 256);
            chk("R6 zero pulse", zc_pulse, ((k % div == 0) && (((k / div) % eff) == 0)) ? 1 : 0);
        end
        chk("R8 irq level", irq, irqen ? 1 : 0);
    endtask

    task automatic counter_run(input int tc, input bit rising, input int pulses);
        int eff = (tc == 0) ? 256 : tc;
        int z0;
        ext_clk_trg = rising ? 1'b0 : 1'b1;
        repeat (4) @(negedge clk);
        wr(8'h45 | (rising ? 8'h10 : 8'h00));
        wr(tc[7:0]);
        z0 = zc_seen;
        for (int p = 1; p <= pulses; p++) begin
            ext_clk_trg = ~ext_clk_trg;
            @(negedge clk);
            @(negedge clk);
            chk("R5 not yet stepped", rd_data, (eff - ((p - 1) % eff)) % 256);
            @(negedge clk);
            chk("R5 counter step", rd_data, (eff - (p % eff)) % 256);
            ext_clk_trg = ~ext_clk_trg;
            repeat (2) @(negedge clk);
        end
        chk("R6 zero pulses in counter mode", zc_seen - z0, pulses / eff);
    endtask

    initial begin
        int v;
        int z;
        repeat (4) @(negedge clk);
        chk("R1 reset count", rd_data, 0);
        chk("R1 reset irq", irq, 0);
        chk("R1 reset zc", zc_pulse, 0);
        rst_n = 1'b1;
        repeat (30) @(negedge clk);
        chk("R1 idle after reset", rd_data, 0);
        chk("R1 no pulse while idle", zc_seen, 0);

        // R4/R6/R8 timer, divide by 16
        timer_run(3, 1'b0, 2, 1'b1, 1'b0);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        chk("R8 ack clears irq", irq, 0);

        // R2 ignored write and R8 interrupt disabled
        timer_run(2, 1'b0, 2, 1'b0, 1'b1);

        // R4 divide by 256
        timer_run(2, 1'b1, 1, 1'b1, 1'b0);

        // R10 soft reset
        timer_run(1, 1'b0, 3, 1'b1, 1'b0);
        wr(8'h03);
        chk("R10 irq cleared", irq, 0);
        v = rd_data;
        z = zc_seen;
        repeat (60) @(negedge clk);
        chk("R10 count frozen", rd_data, v);
        chk("R10 no pulses", zc_seen - z, 0);

        // R5 counter mode, both edge polarities; R7 zero constant
        counter_run(3, 1'b1, 7);
        counter_run(4, 1'b0, 5);
        counter_run(0, 1'b1, 257);

        // R9 trigger start on a falling edge
        ext_clk_trg = 1'b1;
        repeat (4) @(negedge clk);
        wr(8'h0D);
        wr(8'd2);
        repeat (40) @(negedge clk);
        chk("R9 waits for trigger", rd_data, 2);
        ext_clk_trg = 1'b0;
        repeat (3) @(negedge clk);
        repeat (15) @(negedge clk);
        chk("R9 no step before 16 clocks", rd_data, 2);
        @(negedge clk);
        chk("R9 first step after trigger", rd_data, 1);

        // R11 hardware reset clears a pending interrupt
        timer_run(1, 1'b0, 1, 1'b1, 1'b0);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R11 irq cleared by reset", irq, 0);
        chk("R11 count cleared by reset", rd_data, 0);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        chk("R11 stays stopped", rd_data, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end
endmodule